// File: doc/BRIEF.md
# PS/2 Keyboard Key Press/Release Tracker

This block receives scan codes from a PS/2 keyboard and reports whether a single key is held down. A note player uses it to start a tone when a key goes down and stop it when the key comes back up. Every flop runs on the system clock. Both keyboard lines are cleaned by sample filters. A bit is taken on each falling edge of the filtered keyboard clock, and that edge is found by comparing the filtered clock with a one-cycle-delayed copy. No flop is clocked by the keyboard.

Each frame is 11 bits and is checked before its data byte is passed on. A small state machine watches for the release prefix byte 0xF0. A make code sets the held flag. A release of the held key clears the flag on the next accepted byte. So a note neither lags by a frame nor keeps sounding after release. The block drives the current code, the held flag, a one-cycle event strobe and the two most recent bytes.

A keyboard cannot be stalled, so the outputs have no ready input and nothing applies back-pressure. The event strobe is a plain one-cycle pulse. A consumer that needs the change must act on it in that cycle.

Top module: `ps2_key_tracker`

## Requirements
- R1: A filtered line takes a new level only after eight consecutive system-clock samples at that level. A pulse on either line shorter than eight samples has no effect on decoding.
- R2: A bit is shifted in on each falling edge of the filtered PS/2 clock. The frame is LSB first: bit 0 is the start bit, bits 1..8 are the data byte with its LSB first, bit 9 is parity and bit 10 is the stop bit.
- R3: A frame is accepted only if its start bit is 0, its stop bit is 1 and the data bits plus the parity bit hold an odd number of ones. A rejected frame changes no output.
- R4: On every accepted byte, `byte_pair` shifts: the previous low byte moves to bits 15:8 and the new byte enters bits 7:0.
- R5: An accepted byte other than 0xF0 that arrives with no release pending is a press. If no key is held, or the byte differs from `key_code`, the block stores the byte in `key_code`, sets `key_held` and pulses `key_evt`.
- R6: A press byte equal to the held `key_code` (a repeat) changes neither `key_held` nor `key_code` and gives no strobe.
- R7: Byte 0xF0 makes a release pending. The next accepted byte, if it equals the held code, clears `key_held` and pulses `key_evt`, and `key_code` keeps its value.
- R8: A byte that follows 0xF0 but does not match the held code clears the pending release and has no other effect on `key_held` or `key_code`.
- R9: If a frame is partly received and no filtered clock falling edge arrives for TIMEOUT_CYC cycles (2500 by default, 100 us at 25 MHz), the bit count restarts. A following complete frame then decodes correctly.
- R10: `key_evt` is high for exactly one cycle, in exactly the cycles where `key_held` or `key_code` has just changed.
- R11: Synchronous reset clears `key_code`, `key_held`, `key_evt`, `byte_pair`, the pending release and the frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Raw PS/2 clock line |
| ps2_dat_i | input | 1 | Raw PS/2 data line |
| key_code | output | 8 | Scan code of the last key pressed |
| key_held | output | 1 | High while that key is down |
| key_evt | output | 1 | One-cycle pulse when key_held or key_code changes |
| byte_pair | output | 16 | Older accepted byte in 15:8, newest in 7:0 |

## Verification
The clock filter and the data filter can switch in the same cycle. When that happens, the falling-edge detector must capture the data level that has just settled. The bench provokes this by sending one whole frame with each data change driven in the same cycle as the clock fall. The bench's cycle-by-cycle model takes the new data value as the captured bit. Its decoded code and strobe timing are compared with the design on every clock.

// File: rtl/ps2_trk_pkg.sv
package ps2_trk_pkg;
  localparam int          CODE_W     = 8;
  localparam int          FRAME_BITS = CODE_W + 3;
  localparam logic [7:0]  REL_PREFIX = 8'hF0;

  typedef enum logic { REL_NONE, REL_PENDING } rel_state_e;
endpackage

// File: rtl/ps2_glitch_filter.sv
module ps2_glitch_filter #(
  parameter int TAPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [TAPS-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
      dout <= 1'b1;
    end else begin
      hist <= {din, hist[TAPS-1:1]};
      if (&hist)       dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_trk_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_f,
  input  logic              dat_f,
  output logic              byte_vld,
  output logic [CODE_W-1:0] byte_q
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic                  clk_d;
  logic                  fall;
  logic [CW-1:0]         bit_cnt;
  logic [TW-1:0]         idle;
  logic [FRAME_BITS-1:0] shreg, sh_nxt;
  logic                  frame_ok;

  assign fall     = clk_d & ~clk_f;
  assign sh_nxt   = {dat_f, shreg[FRAME_BITS-1:1]};
  assign frame_ok = ~sh_nxt[0] & sh_nxt[FRAME_BITS-1] & (^sh_nxt[FRAME_BITS-2:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d    <= 1'b1;
      bit_cnt  <= '0;
      idle     <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      clk_d    <= clk_f;
      byte_vld <= 1'b0;
      if (fall) begin
        shreg <= sh_nxt;
        idle  <= '0;
        if (bit_cnt == CW'(FRAME_BITS - 1)) begin
          bit_cnt <= '0;
          if (frame_ok) begin
            byte_vld <= 1'b1;
            byte_q   <= sh_nxt[CODE_W:1];
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle == TW'(TIMEOUT_CYC - 1)) begin
          bit_cnt <= '0;
          idle    <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_key_fsm.sv
module ps2_key_fsm
  import ps2_trk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_vld,
  input  logic [CODE_W-1:0]   byte_i,
  output logic [CODE_W-1:0]   key_code,
  output logic                key_held,
  output logic                key_evt,
  output logic [2*CODE_W-1:0] byte_pair
);
  rel_state_e rel_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_st    <= REL_NONE;
      key_code  <= '0;
      key_held  <= 1'b0;
      key_evt   <= 1'b0;
      byte_pair <= '0;
    end else begin
      key_evt <= 1'b0;
      if (byte_vld) begin
        byte_pair <= {byte_pair[CODE_W-1:0], byte_i};
        if (byte_i == REL_PREFIX) begin
          rel_st <= REL_PENDING;
        end else if (rel_st == REL_PENDING) begin
          rel_st <= REL_NONE;
          if (key_held && byte_i == key_code) begin
            key_held <= 1'b0;
            key_evt  <= 1'b1;
          end
        end else if (!key_held || byte_i != key_code) begin
          key_code <= byte_i;
          key_held <= 1'b1;
          key_evt  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_key_tracker.sv
module ps2_key_tracker
  import ps2_trk_pkg::*;
#(
  parameter int FILT_TAPS   = 8,
  parameter int TIMEOUT_CYC = 2500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ps2_clk_i,
  input  logic                ps2_dat_i,
  output logic [CODE_W-1:0]   key_code,
  output logic                key_held,
  output logic                key_evt,
  output logic [2*CODE_W-1:0] byte_pair
);
  logic [1:0]        raw_lines, filt_lines;
  logic              byte_vld;
  logic [CODE_W-1:0] byte_q;

  assign raw_lines = {ps2_dat_i, ps2_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    ps2_glitch_filter #(.TAPS(FILT_TAPS)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .clk_f   (filt_lines[0]),
    .dat_f   (filt_lines[1]),
    .byte_vld(byte_vld),
    .byte_q  (byte_q)
  );

  ps2_key_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (byte_vld),
    .byte_i   (byte_q),
    .key_code (key_code),
    .key_held (key_held),
    .key_evt  (key_evt),
    .byte_pair(byte_pair)
  );
endmodule

// File: rtl/ps2_key_tracker_chk.sv
module ps2_key_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  key_code,
  input logic        key_held,
  input logic        key_evt,
  input logic [15:0] byte_pair
);
  // R10: a strobe only where the held flag or the code has changed
  p_evt_needs_change_r10: assert property (@(posedge clk) disable iff (rst)
    key_evt |-> ((key_held != $past(key_held)) || (key_code != $past(key_code))));

  // R10: every change of the held flag or the code carries a strobe
  p_change_needs_evt_r10: assert property (@(posedge clk) disable iff (rst)
    ((key_held != $past(key_held)) || (key_code != $past(key_code))) |-> key_evt);

  // R10: the strobe lasts a single cycle
  p_evt_single_r10: assert property (@(posedge clk) disable iff (rst)
    key_evt |=> !key_evt);

  // R7: a release leaves the stored code in place
  p_release_keeps_code_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(key_held) |-> $stable(key_code));

  // R4: the upper byte of the pair takes the previous lower byte
  p_pair_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_pair != $past(byte_pair)) |-> (byte_pair[15:8] == $past(byte_pair[7:0])));
endmodule

bind ps2_key_tracker ps2_key_tracker_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .key_code (key_code),
  .key_held (key_held),
  .key_evt  (key_evt),
  .byte_pair(byte_pair)
);

// File: tb/ps2_key_tracker_bench.sv
`timescale 1ns/1ps
module ps2_key_tracker_bench;
  localparam int TO   = 2500;
  localparam int HALF = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ps2_clk = 1'b1;
  logic        ps2_dat = 1'b1;
  logic [7:0]  key_code;
  logic        key_held, key_evt;
  logic [15:0] byte_pair;

  int checks = 0, errors = 0, evt_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  ps2_key_tracker #(.FILT_TAPS(8), .TIMEOUT_CYC(TO)) u_ps2_key_tracker (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .key_code(key_code), .key_held(key_held), .key_evt(key_evt), .byte_pair(byte_pair)
  );

  // behavioural reference model
  int   c_run, d_run, idle;
  bit   c_val, d_val, m_cf, m_df, m_cprev, m_bv, m_pend, m_held, m_evt;
  bit   q[$];
  bit [7:0]  m_byte, m_code;
  bit [15:0] m_pair;

  always @(posedge clk) begin
    bit fall, bv_new, par;
    bit [7:0] b;
    if (rst) begin
      c_run = 8; d_run = 8; c_val = 1; d_val = 1; m_cf = 1; m_df = 1; m_cprev = 1;
      m_bv = 0; m_pend = 0; m_held = 0; m_evt = 0; m_code = 0; m_pair = 0; m_byte = 0;
      idle = 0; q.delete();
    end else begin
      m_evt = 0;
      if (m_bv) begin
        m_pair = {m_pair[7:0], m_byte};
        if (m_byte == 8'hF0) m_pend = 1;
        else if (m_pend) begin
          m_pend = 0;
          if (m_held && m_byte == m_code) begin m_held = 0; m_evt = 1; end
        end else if (!m_held || m_byte != m_code) begin
          m_code = m_byte; m_held = 1; m_evt = 1;
        end
      end
      fall = m_cprev && !m_cf;
      bv_new = 0;
      if (fall) begin
        q.push_back(m_df);
        idle = 0;
        if (q.size() == 11) begin
          b = 0; par = 0;
          for (int i = 0; i < 8; i++) b[i] = q[i+1];
          for (int i = 1; i <= 9; i++) par ^= q[i];
          if (!q[0] && q[10] && par) begin bv_new = 1; m_byte = b; end
          q.delete();
        end
      end else if (q.size() > 0) begin
        idle++;
        if (idle == TO) begin q.delete(); idle = 0; end
      end
      m_bv = bv_new;
      m_cprev = m_cf;
      if (c_run >= 8) m_cf = c_val;
      if (d_run >= 8) m_df = d_val;
      if (ps2_clk == c_val) c_run++; else begin c_val = ps2_clk; c_run = 1; end
      if (ps2_dat == d_val) d_run++; else begin d_val = ps2_dat; d_run = 1; end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (key_evt) evt_cnt++;
      check("R5/R7/R10 model key_code", key_code, m_code);
      check("R5/R7/R10 model key_held", key_held, m_held);
      check("R10 model key_evt", key_evt, m_evt);
      check("R4 model byte_pair", byte_pair, m_pair);
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                            input bit coinc, input int nbits);
    logic [10:0] fb;
    fb = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      if (coinc) begin
        ps2_dat = fb[i]; ps2_clk = 1'b0;
        wait_cyc(HALF); ps2_clk = 1'b1; wait_cyc(HALF);
      end else begin
        ps2_dat = fb[i]; wait_cyc(HALF);
        ps2_clk = 1'b0; wait_cyc(HALF); ps2_clk = 1'b1;
      end
    end
    wait_cyc(HALF);
    ps2_dat = 1'b1;
    wait_cyc(40);
  endtask

  task automatic key(input logic [7:0] b);
    send_frame(b, 0, 0, 0, 11);
  endtask

  initial begin
    wait_cyc(5);
    check("R11 reset key_held", key_held, 0);
    check("R11 reset key_code", key_code, 0);
    check("R11 reset byte_pair", byte_pair, 0);
    rst = 1'b0;
    wait_cyc(20);

    key(8'h1C);
    check("R5 press held", key_held, 1);
    check("R2 press code LSB first", key_code, 8'h1C);
    check("R5 press strobe count", evt_cnt, 1);

    key(8'h1C);
    check("R6 repeat no strobe", evt_cnt, 1);
    check("R4 pair after repeat", byte_pair, 16'h1C1C);

    key(8'h1B);
    check("R5 new key code", key_code, 8'h1B);
    check("R5 new key strobe", evt_cnt, 2);

    key(8'hF0); key(8'h1C);
    check("R8 foreign release held", key_held, 1);
    check("R8 foreign release code", key_code, 8'h1B);
    check("R8 foreign release strobe", evt_cnt, 2);

    key(8'hF0); key(8'h1B);
    check("R7 release held", key_held, 0);
    check("R7 release code kept", key_code, 8'h1B);
    check("R7 release strobe", evt_cnt, 3);

    send_frame(8'h23, 1, 0, 0, 11);
    check("R3 bad parity pair", byte_pair, 16'hF01B);
    send_frame(8'h23, 0, 1, 0, 11);
    check("R3 bad stop pair", byte_pair, 16'hF01B);
    check("R3 bad frames held", key_held, 0);

    ps2_clk = 1'b0; wait_cyc(5); ps2_clk = 1'b1; wait_cyc(10);
    ps2_dat = 1'b0; wait_cyc(6); ps2_dat = 1'b1; wait_cyc(30);
    send_frame(8'h23, 0, 0, 1, 11);
    check("R1 glitch ignored code", key_code, 8'h23);
    check("R1 coincident edges held", key_held, 1);

    send_frame(8'h4D, 0, 0, 0, 4);
    wait_cyc(TO + 200);
    key(8'hF0); key(8'h23);
    check("R9 timeout realign held", key_held, 0);
    check("R9 timeout realign pair", byte_pair, 16'hF023);

    key(8'h2A);
    rst = 1'b1; wait_cyc(3);
    check("R11 mid-run reset held", key_held, 0);
    check("R11 mid-run reset pair", byte_pair, 0);
    check("R11 mid-run reset evt", key_evt, 0);
    rst = 1'b0; wait_cyc(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule